// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave end of a four-wire SPI link (active-low select, serial clock, data in, data out) placed in front of a byte-wide storage array. The host lowers the select line, clocks an 8-bit opcode in most significant bit first, and then, depending on the opcode, either streams bytes out of the array or reads back a one-byte status word. A write-enable latch is set and cleared by two dedicated opcodes. The latch is visible in the status word, and it is the flag that a programming engine outside this block consults before it commits any write.

The SPI pins are oversampled in the system clock domain. A short synchroniser chain feeds an edge detector, so the whole block runs on one clock. The array is built from plain registers. A parallel initialisation port fills it before any serial traffic. The default depth is 2^11 bytes; setting `ADDR_W` to 13 gives the 8K-byte configuration, whose top address is 1FFFh. Data out is accompanied by an output-enable, and the pad buffer at chip level uses it to float the line.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the write-enable latch is clear and `spi_miso_oe` is low. A status read issued first after reset returns latch bit 1 as 0.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. The change shows in bit 1 of the status word.
- R3: While `spi_cs_n` is high, `spi_miso_oe` is low. Raising `spi_cs_n` aborts any read in progress. The next low level starts a fresh opcode.
- R4: Opcode 03h is followed by a 16-bit address, most significant bit first. Only the low `ADDR_W` bits select the first byte; the address bits above them are ignored.
- R5: After the address, the array bytes are driven most significant bit first at consecutive addresses, one byte per 8 serial clocks, for as long as clocks continue.
- R6: After the byte at address 2^ADDR_W-1 the read continues at address 0.
- R7: Opcode 05h returns the status word {6'b0, latch, busy}, where bit 0 is `wr_busy`. The word is resent every 8 serial clocks, and it can be read while `wr_busy` is high.
- R8: `spi_miso_oe` stays low while opcode and address bits are received. It first rises at the falling clock edge that follows the last address bit, or the last opcode bit for a status read.
- R9: Data in is sampled on rising serial clock edges. Data out changes only on falling edges (mode 0).
- R10: Any other opcode leaves `spi_miso_oe` low and the latch unchanged until select rises again.
- R11: A write on the initialisation port stores `init_data` at `init_addr`, and later serial reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | High when `spi_miso` must be driven; low means high impedance |
| wr_busy | input | 1 | Internal write in progress, reported in status bit 0 |
| init_we | input | 1 | Initialisation write strobe |
| init_addr | input | ADDR_W | Initialisation write address |
| init_data | input | 8 | Initialisation write data |

## Verification
The bench attacks the wrap from the top address back to zero. A pointer that saturated, or that carried into bits the array lacks, would return the wrong bytes or the top byte repeated. Addresses with the ignored high bits set catch a decoder that uses the full 16 bits. Status reads taken while busy is high, and repeated over several bytes, catch a word that is latched only once or that drops the busy flag. An unknown opcode placed between the latch commands catches a decoder that falls through into a read or touches the latch. The per-clock comparison of output-enable catches driving the line during address bits, or any output change on a rising edge.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_RDATA,
        PH_RSTAT,
        PH_DONE
    } phase_e;

    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;

    localparam int CMD_BITS = 8;
    localparam int ADR_BITS = 16;
    localparam int CNT_W    = $clog2(ADR_BITS);

    function automatic logic [7:0] status_byte(input logic wel, input logic busy);
        return {6'b0, wel, busy};
    endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic sel,
    output logic rise,
    output logic fall,
    output logic si_s
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dat;
        logic              ck_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.cs[0]  = cs_n;
        s_d.ck[0]  = sck;
        s_d.dat[0] = si;
        for (int i = 1; i < STAGES; i++) begin
            s_d.cs[i]  = s_q.cs[i-1];
            s_d.ck[i]  = s_q.ck[i-1];
            s_d.dat[i] = s_q.dat[i-1];
        end
        s_d.ck_prev = s_q.ck[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cs      <= '1;
            s_q.ck      <= '0;
            s_q.dat     <= '0;
            s_q.ck_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel  = ~s_q.cs[LAST];
    assign rise = s_q.ck[LAST] & ~s_q.ck_prev;
    assign fall = ~s_q.ck[LAST] & s_q.ck_prev;
    assign si_s = s_q.dat[LAST];

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              fall,
    input  logic              si,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wel_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              adv_o,
    output logic              so_oe,
    output logic              so_data
);

    localparam int SR_W = ((ADDR_W > CMD_BITS) ? ADDR_W : CMD_BITS) - 1;
    localparam int FR_W = SR_W + 1;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [SR_W-1:0]   sr;
        logic [ADDR_W-1:0] ptr;
        logic [7:0]        obyte;
        logic [2:0]        idx;
        logic              wel;
        logic              oe;
        logic              dout;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  [FR_W-1:0] frame;
    logic             adv;

    assign frame   = {c_q.sr, si};
    assign rd_addr = (c_q.ph == PH_ADDR) ? frame[ADDR_W-1:0] : c_q.ptr + 1'b1;

    always_comb begin
        c_d = c_q;
        adv = 1'b0;
        if (!sel) begin
            c_d.ph  = PH_CMD;
            c_d.cnt = '0;
            c_d.idx = '0;
            c_d.oe  = 1'b0;
        end else if (rise) begin
            case (c_q.ph)
                PH_CMD: begin
                    c_d.sr  = {c_q.sr[SR_W-2:0], si};
                    c_d.cnt = c_q.cnt + 1'b1;
                    if (c_q.cnt == CNT_W'(CMD_BITS - 1)) begin
                        c_d.cnt = '0;
                        case (frame[7:0])
                            OPC_READ: c_d.ph = PH_ADDR;
                            OPC_RDSR: begin
                                c_d.ph    = PH_RSTAT;
                                c_d.obyte = status_byte(c_q.wel, busy);
                                c_d.idx   = '0;
                            end
                            OPC_WREN: begin
                                c_d.wel = 1'b1;
                                c_d.ph  = PH_DONE;
                            end
                            OPC_WRDI: begin
                                c_d.wel = 1'b0;
                                c_d.ph  = PH_DONE;
                            end
                            default: c_d.ph = PH_DONE;
                        endcase
                    end
                end
                PH_ADDR: begin
                    c_d.sr  = {c_q.sr[SR_W-2:0], si};
                    c_d.cnt = c_q.cnt + 1'b1;
                    if (c_q.cnt == CNT_W'(ADR_BITS - 1)) begin
                        c_d.ph    = PH_RDATA;
                        c_d.ptr   = frame[ADDR_W-1:0];
                        c_d.obyte = rd_data;
                        c_d.idx   = '0;
                    end
                end
                default: ;
            endcase
        end else if (fall && (c_q.ph == PH_RDATA || c_q.ph == PH_RSTAT)) begin
            c_d.oe   = 1'b1;
            c_d.dout = c_q.obyte[~c_q.idx];
            c_d.idx  = c_q.idx + 3'd1;
            if (c_q.idx == 3'd7) begin
                if (c_q.ph == PH_RDATA) begin
                    c_d.ptr   = c_q.ptr + 1'b1;
                    c_d.obyte = rd_data;
                    adv       = 1'b1;
                end else begin
                    c_d.obyte = status_byte(c_q.wel, busy);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.ph    <= PH_CMD;
            c_q.cnt   <= '0;
            c_q.sr    <= '0;
            c_q.ptr   <= '0;
            c_q.obyte <= '0;
            c_q.idx   <= '0;
            c_q.wel   <= 1'b0;
            c_q.oe    <= 1'b0;
            c_q.dout  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign wel_o   = c_q.wel;
    assign ptr_o   = c_q.ptr;
    assign adv_o   = adv;
    assign so_oe   = c_q.oe;
    assign so_data = c_q.dout;

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              wr_busy,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [7:0]        init_data
);

    logic              sel_w;
    logic              rise_w;
    logic              fall_w;
    logic              si_w;
    logic [ADDR_W-1:0] rd_addr_w;
    logic [7:0]        rd_data_w;
    logic              wel_w;
    logic [ADDR_W-1:0] ptr_w;
    logic              adv_w;

    spi_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .cs_n (spi_cs_n),
        .sck  (spi_sck),
        .si   (spi_mosi),
        .sel  (sel_w),
        .rise (rise_w),
        .fall (fall_w),
        .si_s (si_w)
    );

    spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_w),
        .rise   (rise_w),
        .fall   (fall_w),
        .si     (si_w),
        .busy   (wr_busy),
        .rd_data(rd_data_w),
        .rd_addr(rd_addr_w),
        .wel_o  (wel_w),
        .ptr_o  (ptr_w),
        .adv_o  (adv_w),
        .so_oe  (spi_miso_oe),
        .so_data(spi_miso)
    );

    spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk    (clk),
        .wr_en  (init_we),
        .wr_addr(init_addr),
        .wr_data(init_data),
        .rd_addr(rd_addr_w),
        .rd_data(rd_data_w)
    );

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              rise,
    input logic              fall,
    input logic              wel,
    input logic [ADDR_W-1:0] ptr,
    input logic              adv,
    input logic              so_oe,
    input logic              so_data
);

    assert_wel_clear_on_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wel);

    assert_wel_moves_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wel != $past(wel)) |-> $past(rise));

    assert_hiz_when_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !so_oe);

    assert_ptr_steps_and_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv) |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    assert_drive_starts_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(fall));

    assert_data_moves_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so_data != $past(so_data))) |-> $past(fall));

endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel_w),
    .rise   (rise_w),
    .fall   (fall_w),
    .wel    (wel_w),
    .ptr    (ptr_w),
    .adv    (adv_w),
    .so_oe  (spi_miso_oe),
    .so_data(spi_miso)
);

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int SYNC  = 2;
    localparam int LAT   = SYNC + 1;
    localparam int H     = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cs_n  = 1'b1;
    logic          sck   = 1'b0;
    logic          mosi  = 1'b0;
    logic          busy  = 1'b0;
    logic          iwe   = 1'b0;
    logic [AW-1:0] iaddr = '0;
    logic [7:0]    idata = '0;
    logic          miso;
    logic          miso_oe;

    spi_mem_slave #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_cs_n   (cs_n),
        .spi_sck    (sck),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .spi_miso_oe(miso_oe),
        .wr_busy    (busy),
        .init_we    (iwe),
        .init_addr  (iaddr),
        .init_data  (idata)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int   m_mem [DEPTH];
    logic m_sck = 1'b0;
    int   m_ph = 0, m_n = 0, m_acc = 0, m_ptr = 0, m_pos = 7, m_byte = 0;
    logic m_wel = 1'b0, m_oe = 1'b0, m_bit = 1'b0;
    logic eh_oe  [LAT];
    logic eh_bit [LAT];

    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    bit         oe_q[$];
    bit         seen_oe;

    function automatic logic [7:0] pat(input int a);
        return 8'(((a * 37) + 11) ^ (a >> 4));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        if (cs_n) begin
            m_oe = 1'b0; m_ph = 0; m_n = 0; m_acc = 0;
        end else if (sck && !m_sck) begin
            if (m_ph == 0) begin
                m_acc = ((m_acc << 1) | int'(mosi)) & 255;
                m_n++;
                if (m_n == 8) begin
                    m_n = 0;
                    case (m_acc)
                        3: begin m_ph = 1; m_acc = 0; end
                        5: begin m_ph = 3; m_byte = int'(m_wel) * 2 + int'(busy); m_pos = 7; end
                        6: begin m_wel = 1'b1; m_ph = 4; end
                        4: begin m_wel = 1'b0; m_ph = 4; end
                        default: m_ph = 4;
                    endcase
                end
            end else if (m_ph == 1) begin
                m_acc = ((m_acc << 1) | int'(mosi)) & 16'hFFFF;
                m_n++;
                if (m_n == 16) begin
                    m_ptr = m_acc % DEPTH; m_byte = m_mem[m_ptr]; m_pos = 7; m_ph = 2;
                end
            end
        end else if (!sck && m_sck && (m_ph == 2 || m_ph == 3)) begin
            m_oe  = 1'b1;
            m_bit = m_byte[m_pos];
            m_pos--;
            if (m_pos < 0) begin
                m_pos = 7;
                if (m_ph == 2) begin
                    m_ptr = (m_ptr + 1) % DEPTH; m_byte = m_mem[m_ptr];
                end else begin
                    m_byte = int'(m_wel) * 2 + int'(busy);
                end
            end
        end
        m_sck = sck;
    endtask

    // one clock: compare against the prediction made LAT clocks ago, then drive
    task automatic step(input logic c, input logic k, input logic d);
        @(negedge clk);
        check(miso_oe == eh_oe[LAT-1], cur_req, "miso_oe", int'(miso_oe), int'(eh_oe[LAT-1]));
        if (eh_oe[LAT-1])
            check(miso == eh_bit[LAT-1], cur_req, "miso", int'(miso), int'(eh_bit[LAT-1]));
        if (miso_oe) seen_oe = 1'b1;
        for (int i = LAT - 1; i > 0; i--) begin
            eh_oe[i]  = eh_oe[i-1];
            eh_bit[i] = eh_bit[i-1];
        end
        cs_n = c; sck = k; mosi = d;
        model_update();
        eh_oe[0]  = m_oe;
        eh_bit[0] = m_bit;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [7:0] got;
        bit         any_oe;
        logic       v0;
        any_oe = 1'b0;
        got    = '0;
        for (int i = 7; i >= 0; i--) begin
            for (int s = 0; s < H; s++) begin
                step(1'b0, 1'b0, b[i]);
                if (miso_oe) any_oe = 1'b1;
            end
            got[i] = miso;
            step(1'b0, 1'b1, b[i]);
            v0 = miso;
            for (int s = 1; s < H; s++) begin
                step(1'b0, 1'b1, b[i]);
                if (miso_oe) begin
                    any_oe = 1'b1;
                    check(miso == v0, "R9", "miso moved while sck high", int'(miso), int'(v0));
                end
            end
        end
        rx_q.push_back(got);
        oe_q.push_back(any_oe);
    endtask

    task automatic xfer();
        rx_q.delete();
        oe_q.delete();
        step(1'b1, 1'b0, 1'b0);
        for (int s = 0; s < H; s++) step(1'b0, 1'b0, 1'b0);
        foreach (tx_q[i]) send_byte(tx_q[i]);
        for (int s = 0; s < H; s++) step(1'b0, 1'b0, 1'b0);
        for (int s = 0; s < LAT + 2; s++) step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic read_status(input int nbytes);
        tx_q.delete();
        tx_q.push_back(8'h05);
        for (int i = 0; i < nbytes; i++) tx_q.push_back(8'h00);
        xfer();
    endtask

    task automatic read_mem(input logic [15:0] a, input int nbytes);
        tx_q.delete();
        tx_q.push_back(8'h03);
        tx_q.push_back(a[15:8]);
        tx_q.push_back(a[7:0]);
        for (int i = 0; i < nbytes; i++) tx_q.push_back(8'h00);
        xfer();
    endtask

    task automatic one_op(input logic [7:0] op);
        tx_q.delete();
        tx_q.push_back(op);
        xfer();
    endtask

    initial begin
        for (int i = 0; i < LAT; i++) begin eh_oe[i] = 1'b0; eh_bit[i] = 1'b0; end
        repeat (5) @(negedge clk);
        check(miso_oe == 1'b0, "R1", "miso_oe in reset", int'(miso_oe), 0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0);
        check(miso_oe == 1'b0, "R1", "miso_oe after reset", int'(miso_oe), 0);

        cur_req = "R11";
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b1, 1'b0, 1'b0);
            iwe = 1'b1; iaddr = AW'(a); idata = pat(a); m_mem[a] = int'(pat(a));
        end
        step(1'b1, 1'b0, 1'b0);
        iwe = 1'b0;

        cur_req = "R7";
        read_status(2);
        check(rx_q[1] == 8'h00, "R1", "status after reset", int'(rx_q[1]), 0);
        check(rx_q[2] == 8'h00, "R7", "status repeated", int'(rx_q[2]), 0);

        cur_req = "R2";
        one_op(8'h06);
        read_status(1);
        check(rx_q[1] == 8'h02, "R2", "status after set opcode", int'(rx_q[1]), 2);

        cur_req = "R7";
        busy = 1'b1;
        read_status(3);
        check(rx_q[1] == 8'h03, "R7", "status while busy", int'(rx_q[1]), 3);
        check(rx_q[3] == 8'h03, "R7", "status third repeat", int'(rx_q[3]), 3);
        busy = 1'b0;

        cur_req = "R10";
        seen_oe = 1'b0;
        tx_q.delete();
        tx_q.push_back(8'hA5); tx_q.push_back(8'hFF); tx_q.push_back(8'h04);
        xfer();
        check(seen_oe == 1'b0, "R10", "drive after unknown opcode", int'(seen_oe), 0);
        read_status(1);
        check(rx_q[1] == 8'h02, "R10", "latch after unknown opcode", int'(rx_q[1]), 2);

        cur_req = "R2";
        one_op(8'h04);
        read_status(1);
        check(rx_q[1] == 8'h00, "R2", "status after clear opcode", int'(rx_q[1]), 0);

        cur_req = "R8";
        read_mem(16'h0010, 3);
        check(oe_q[0] == 1'b0 && oe_q[1] == 1'b0 && oe_q[2] == 1'b0, "R8",
              "drive during opcode or address", int'(oe_q[2]), 0);
        check(oe_q[3] == 1'b1, "R8", "drive in first data byte", int'(oe_q[3]), 1);
        check(rx_q[3] == pat(16'h010), "R5", "byte 0010h", int'(rx_q[3]), int'(pat(16'h010)));
        check(rx_q[4] == pat(16'h011), "R5", "byte 0011h", int'(rx_q[4]), int'(pat(16'h011)));
        check(rx_q[5] == pat(16'h012), "R11", "byte 0012h", int'(rx_q[5]), int'(pat(16'h012)));

        cur_req = "R6";
        read_mem(16'(DEPTH - 2), 4);
        check(rx_q[3] == pat(DEPTH - 2), "R6", "byte top-1", int'(rx_q[3]), int'(pat(DEPTH - 2)));
        check(rx_q[4] == pat(DEPTH - 1), "R6", "byte top", int'(rx_q[4]), int'(pat(DEPTH - 1)));
        check(rx_q[5] == pat(0), "R6", "byte after wrap", int'(rx_q[5]), int'(pat(0)));
        check(rx_q[6] == pat(1), "R6", "second byte after wrap", int'(rx_q[6]), int'(pat(1)));

        cur_req = "R4";
        read_mem(16'hF805, 2);
        check(rx_q[3] == pat(5), "R4", "high address bits ignored", int'(rx_q[3]), int'(pat(5)));
        check(rx_q[4] == pat(6), "R4", "next byte", int'(rx_q[4]), int'(pat(6)));

        cur_req = "R3";
        read_mem(16'h0100, 1);
        check(miso_oe == 1'b0, "R3", "miso_oe after select rises", int'(miso_oe), 0);
        check(rx_q[3] == pat(16'h100), "R3", "byte before abort", int'(rx_q[3]), int'(pat(16'h100)));
        read_status(1);
        check(rx_q[1] == 8'h00, "R3", "fresh opcode after abort", int'(rx_q[1]), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule